// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block sorts every 32-bit virtual address into one of five fixed segments. It uses the current privilege level and the error-level status bit to decide the outcome. There are three possible results. A directly translated address comes out on a bypass output. A mapped address raises a request for page-table translation. An access that the current privilege level may not make raises an address error, which is split into a load case and a store case.

The decoder is purely combinational and sits in front of the translation lookaside stage of a load/store or fetch path. Each input address is classified in the same cycle. It holds no state and has no handshake: the outputs follow the inputs.

The two directly translated kernel windows differ only in their base. One subtracts 0x80000000 and the other subtracts 0xA0000000. When the error-level bit is set, the low half of the address space passes through unchanged instead of being translated.

Top module: `seg_addr_decoder`

## Requirements
- R1: An address at or below 0x7FFFFFFF with err_level low gives seg_id 0 and need_xlat high. It raises no error in any privilege mode, and phys_addr is 0.
- R2: An address at or below 0x7FFFFFFF with err_level high gives seg_id 0 and phys_addr equal to vaddr. need_xlat and addr_err are both low.
- R3: An address in 0x80000000..0x9FFFFFFF in kernel mode gives seg_id 1 and phys_addr = vaddr - 0x80000000, with need_xlat low.
- R4: An address in 0xA0000000..0xBFFFFFFF in kernel mode gives seg_id 2 and phys_addr = vaddr - 0xA0000000, with need_xlat low.
- R5: An access to either kernel direct window (seg_id 1 or 2) from supervisor or user mode raises addr_err. need_xlat is low and phys_addr is 0.
- R6: An address in 0xC0000000..0xDFFFFFFF gives seg_id 3. It raises need_xlat in kernel or supervisor mode and addr_err in user mode.
- R7: An address in 0xE0000000..0xFFFFFFFF gives seg_id 4. It raises need_xlat in kernel mode only and addr_err otherwise.
- R8: err_store is high exactly when addr_err is high and is_store is high. An address error with is_store low is a load/fetch error.
- R9: priv_mode encodes 00 kernel, 01 supervisor and 10 user. The code 11 behaves exactly like user.
- R10: need_xlat and addr_err are never high together. err_level has no effect outside the 0x00000000..0x7FFFFFFF range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address to classify |
| priv_mode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level status; makes the low half identity-mapped |
| is_store | input | 1 | High for a store, low for a load or fetch |
| seg_id | output | 3 | Segment: 0 low user, 1 kernel direct A, 2 kernel direct B, 3 supervisor mapped, 4 kernel mapped |
| phys_addr | output | 32 | Directly translated address; 0 when none applies |
| need_xlat | output | 1 | Address must be translated through the page table |
| addr_err | output | 1 | Privilege violation |
| err_store | output | 1 | The violation came from a store |

## Verification
The decoder holds no state, so any fault in it shows on the ports for the same address that triggers it. There is no delay to wait out. A wrong segment boundary or a swapped privilege term corrupts seg_id, need_xlat or addr_err only for the addresses on one side of that boundary, and only for one mode. This is why every window edge is driven in all four mode codes, with err_level both high and low. A wrong base subtraction shows up as a wrong phys_addr, but only in the affected window with kernel mode.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  typedef enum logic [2:0] {
    SEG_LOW_USER  = 3'd0,
    SEG_KDIR_A    = 3'd1,
    SEG_KDIR_B    = 3'd2,
    SEG_SUP_MAP   = 3'd3,
    SEG_KERN_MAP  = 3'd4
  } seg_e;

  typedef enum logic [1:0] {
    PRV_KERNEL = 2'b00,
    PRV_SUPER  = 2'b01,
    PRV_USER   = 2'b10,
    PRV_ALIAS  = 2'b11
  } prv_e;

  typedef struct packed {
    logic allowed;
    logic mapped;
  } gate_t;
endpackage

// File: rtl/seg_region_sel.sv
module seg_region_sel #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  output segdec_pkg::seg_e  seg
);
  import segdec_pkg::*;
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    if (!vaddr[TOP]) begin
      seg = SEG_LOW_USER;
    end else begin
      case (vaddr[TOP-1 -: 2])
        2'b00:   seg = SEG_KDIR_A;
        2'b01:   seg = SEG_KDIR_B;
        2'b10:   seg = SEG_SUP_MAP;
        default: seg = SEG_KERN_MAP;
      endcase
    end
  end

  // R10: the upper half never decodes to the low user segment
  always_comb begin
    p_upper_half_r10: assert (!(vaddr[TOP] && seg == SEG_LOW_USER))
      else $error("upper address decoded as low segment");
  end
endmodule

// File: rtl/seg_priv_gate.sv
module seg_priv_gate (
  input  segdec_pkg::seg_e  seg,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  output segdec_pkg::gate_t gate
);
  import segdec_pkg::*;

  logic is_kern;
  logic is_sup;

  // R9: both codes with the high bit set fall to user rights
  assign is_kern = (priv_mode == PRV_KERNEL);
  assign is_sup  = (priv_mode == PRV_SUPER);

  always_comb begin
    gate = '0;
    case (seg)
      SEG_LOW_USER: begin
        gate.allowed = 1'b1;
        gate.mapped  = !err_level;
      end
      SEG_KDIR_A, SEG_KDIR_B: begin
        gate.allowed = is_kern;
        gate.mapped  = 1'b0;
      end
      SEG_SUP_MAP: begin
        gate.allowed = is_kern || is_sup;
        gate.mapped  = 1'b1;
      end
      default: begin
        gate.allowed = is_kern;
        gate.mapped  = 1'b1;
      end
    endcase
  end

  // R7: supervisor and user never reach the kernel mapped segment
  always_comb begin
    p_kmap_kernel_only_r7: assert (!(seg == SEG_KERN_MAP && gate.allowed && !is_kern))
      else $error("kernel mapped segment opened outside kernel");
  end
endmodule

// File: rtl/seg_bypass_addr.sv
module seg_bypass_addr #(
  parameter int ADDR_W = 32
) (
  input  segdec_pkg::seg_e  seg,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              err_level,
  output logic [ADDR_W-1:0] baddr,
  output logic              bvalid
);
  import segdec_pkg::*;
  localparam int TOP   = ADDR_W - 1;
  localparam int KEEPA = ADDR_W - 1;
  localparam int KEEPB = ADDR_W - 3;

  always_comb begin
    baddr  = '0;
    bvalid = 1'b0;
    case (seg)
      SEG_LOW_USER: begin
        bvalid = err_level;
        baddr  = err_level ? vaddr : '0;
      end
      SEG_KDIR_A: begin
        bvalid = 1'b1;
        baddr  = {{(ADDR_W-KEEPA){1'b0}}, vaddr[KEEPA-1:0]};
      end
      SEG_KDIR_B: begin
        bvalid = 1'b1;
        baddr  = {{(ADDR_W-KEEPB){1'b0}}, vaddr[KEEPB-1:0]};
      end
      default: begin
        bvalid = 1'b0;
        baddr  = '0;
      end
    endcase
  end

  // R3 R4: a direct window result always lands in the low half
  always_comb begin
    p_window_low_r3: assert (!((seg == SEG_KDIR_A || seg == SEG_KDIR_B) && baddr[TOP]))
      else $error("direct window result above low half");
  end
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  input  logic              is_store,
  output logic [2:0]        seg_id,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              need_xlat,
  output logic              addr_err,
  output logic              err_store
);
  import segdec_pkg::*;

  seg_e              seg;
  gate_t             gate;
  logic [ADDR_W-1:0] baddr;
  logic              bvalid;

  seg_region_sel #(.ADDR_W(ADDR_W)) u_region (
    .vaddr (vaddr),
    .seg   (seg)
  );

  seg_priv_gate u_gate (
    .seg       (seg),
    .priv_mode (priv_mode),
    .err_level (err_level),
    .gate      (gate)
  );

  seg_bypass_addr #(.ADDR_W(ADDR_W)) u_bypass (
    .seg       (seg),
    .vaddr     (vaddr),
    .err_level (err_level),
    .baddr     (baddr),
    .bvalid    (bvalid)
  );

  assign seg_id    = seg;
  assign need_xlat = gate.allowed && gate.mapped;
  assign addr_err  = !gate.allowed;
  assign err_store = !gate.allowed && is_store;
  assign phys_addr = (gate.allowed && bvalid) ? baddr : '0;

  // R10: translation request and address error are exclusive
  // R8: a store error flag never appears without an error
  // R5: a refused direct window gives no address
  always_comb begin
    p_xlat_err_excl_r10: assert (!(need_xlat && addr_err))
      else $error("translation and error together");
    p_store_needs_err_r8: assert (!(err_store && !addr_err))
      else $error("store error without error");
    p_err_no_addr_r5: assert (!(addr_err && phys_addr != '0))
      else $error("address produced on error");
  end
endmodule

// File: tb/seg_addr_decoder_tb.sv
module seg_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  priv_mode = '0;
  logic        err_level = 1'b0;
  logic        is_store = 1'b0;
  logic [2:0]  seg_id;
  logic [31:0] phys_addr;
  logic        need_xlat, addr_err, err_store;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  seg_addr_decoder dut_i (
    .vaddr(vaddr), .priv_mode(priv_mode), .err_level(err_level),
    .is_store(is_store), .seg_id(seg_id), .phys_addr(phys_addr),
    .need_xlat(need_xlat), .addr_err(addr_err), .err_store(err_store)
  );

  // Expected model, written from the requirements
  function automatic logic [37:0] model(input logic [31:0] a, input logic [1:0] m,
                                        input logic el, input logic st);
    logic k, s;
    logic [2:0] sid;
    logic [31:0] pa;
    logic nx, ae;
    k = (m == 2'b00);               // R9: 11 behaves as user
    s = (m == 2'b01);
    pa = 32'h0; nx = 1'b0; ae = 1'b0;
    if (a <= 32'h7FFF_FFFF) begin
      sid = 3'd0;
      if (el) pa = a; else nx = 1'b1;   // R1 R2
    end else if (a < 32'hA000_0000) begin
      sid = 3'd1;
      if (k) pa = a - 32'h8000_0000; else ae = 1'b1;   // R3 R5
    end else if (a < 32'hC000_0000) begin
      sid = 3'd2;
      if (k) pa = a - 32'hA000_0000; else ae = 1'b1;   // R4 R5
    end else if (a < 32'hE000_0000) begin
      sid = 3'd3;
      if (k || s) nx = 1'b1; else ae = 1'b1;           // R6
    end else begin
      sid = 3'd4;
      if (k) nx = 1'b1; else ae = 1'b1;                // R7
    end
    return {sid, pa, nx, ae, ae & st};                 // R8
  endfunction

  function automatic string tag_of(input logic [31:0] a, input logic [1:0] m, input logic el);
    if (m == 2'b11) return "R9";
    if (a <= 32'h7FFF_FFFF) return el ? "R2" : "R1";
    if (a < 32'hC000_0000) begin
      if (m != 2'b00) return "R5";
      return (a < 32'hA000_0000) ? "R3" : "R4";
    end
    if (a < 32'hE000_0000) return "R6";
    return "R7";
  endfunction

  task automatic apply(input logic [31:0] a, input logic [1:0] m,
                       input logic el, input logic st);
    logic [37:0] exp_v, got;
    @(negedge clk);
    vaddr = a; priv_mode = m; err_level = el; is_store = st;
    #1;
    exp_v = model(a, m, el, st);
    got = {seg_id, phys_addr, need_xlat, addr_err, err_store};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s a=%h m=%b el=%b st=%b got=%h exp=%h",
               tag_of(a, m, el), a, m, el, st, got, exp_v);
    end
    // R10 and R8 checked on the ports independently
    n_chk++;
    if ((need_xlat && addr_err) || (err_store !== (addr_err && st))) begin
      n_bad++;
      $display("FAIL R10/R8 a=%h got nx=%b ae=%b es=%b exp exclusive, es=%b",
               a, need_xlat, addr_err, err_store, addr_err && st);
    end
  endtask

  initial begin
    logic [31:0] edges [10];
    edges = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
              32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
              32'hE000_0000, 32'hFFFF_FFFF};
    // reset state: all inputs zero, kernel, low segment mapped (R1)
    apply(32'h0, 2'b00, 1'b0, 1'b0);
    // directed window edges in every mode, R10 err_level outside low half
    for (int e = 0; e < 10; e++)
      for (int m = 0; m < 4; m++)
        for (int el = 0; el < 2; el++)
          for (int st = 0; st < 2; st++)
            apply(edges[e], 2'(m), 1'(el), 1'(st));
    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (i % 4 == 0) a[31:29] = 3'(i / 4);
      apply(a, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule